// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Resend

This block sends one byte at a time over a single open-drain smart card I/O line. Each character has a low start bit, eight data bits sent least significant bit first, and an even-parity bit. Every bit lasts one elementary time unit (ETU), which is `etu_div` clock cycles long. After the parity bit, the transmitter releases the line for one ETU. In the middle of that slot it samples the line, because the card pulls the line low there to reject a character. Two guard ETUs follow before anything else is sent.

When the card rejects a character, the block raises a sticky error flag. It then resends the byte it holds, with no action from software, and keeps the transmit-end flag low until a copy goes through cleanly. When a clean copy is accepted, the buffer-empty and transmit-end flags rise together. This raises the transmit request, so a DMA engine only supplies the next byte once the card has accepted the current one. An optional limit on the number of resends stops the block in a stalled state. Only a soft reset releases it.

Top module: `sc_tx_retry`

## Requirements
- R1: After reset `tdre`=1, `tend`=1, `err_flag`=0 and `drive_low`=0 (line released).
- R2: A frame is 10 bits of `etu_div` cycles each: a start bit (0), data bits 0..7 in that order, then a parity bit equal to the XOR of the data bits. `drive_low` is 1 only during 0 bits. The line is released during the error slot (bit time 10) and the two guard ETUs (bit times 11 and 12).
- R3: A `wr_en` pulse while `tdre`=1 captures `wr_data` and clears `tdre` and `tend` on that clock edge. The start bit is driven from that same edge.
- R4: A `wr_en` pulse while `tdre`=0 is ignored: the frame in flight and the held byte are unchanged.
- R5: The line is sampled at cycle `etu_div/2` of the error slot. If it reads low, `err_flag` becomes 1 on the next edge. `eri` = `err_flag` AND `eie`.
- R6: After a rejected frame, the same byte is sent again. The new start bit begins 13 ETU after the previous start bit. `tend`, `tdre` and `txi` stay 0 throughout.
- R7: After a frame that is not rejected, `tdre` and `tend` become 1 on the same edge, 13·`etu_div` cycles after the write edge. `err_flag` is left as it was. `txi` = `tie` AND `tdre` AND `tend`.
- R8: `err_flag` is never cleared by hardware. Only an `err_clr` pulse clears it, and a new error in the same cycle takes priority.
- R9: With `retry_max`=N>0, once N resends have also been rejected the block sends nothing more. `tdre` and `tend` stay 0 and writes are ignored until `sw_rst`, which sets both flags to 1 and leaves `err_flag` unchanged. With `retry_max`=0 there is no limit on resends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous soft reset of the transmitter (does not clear err_flag) |
| etu_div | input | DIV_W | Clock cycles per ETU, must be 2 or more |
| retry_max | input | RETRY_W | Maximum number of resends; 0 means no limit |
| tie | input | 1 | Transmit interrupt enable |
| eie | input | 1 | Error interrupt enable |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to send |
| err_clr | input | 1 | Clears err_flag |
| line_in | input | 1 | Sampled level of the shared I/O line |
| drive_low | output | 1 | 1 = pull the line low; 0 = release it |
| tdre | output | 1 | Transmit data register empty |
| tend | output | 1 | Transmission ended |
| err_flag | output | 1 | Sticky error signal flag |
| txi | output | 1 | Transmit interrupt request |
| eri | output | 1 | Error interrupt request |

## Verification
The bench plays the card. It decodes every frame from the line at mid-bit and decides frame by frame whether to pull the line low in the error slot. It covers the following cases and the wrong behaviour each would expose:
- A single rejection followed by acceptance: a design that raised `tend` after the rejected frame would ask the DMA for the next byte too early.
- Unlimited repeated rejections and a capped run of rejections: a broken retry count would either stall too early or keep sending forever.
- A write arriving mid-frame: if the held byte were overwritten, the resend would carry the wrong byte.
- An odd divider: a misplaced sampling point or guard length would show up as the wrong completion cycle.
- Flag clearing: a design that cleared the sticky error on its own would lose the error before software could see it.

// File: rtl/sc_tx_retry.sv
module sc_tx_retry #(
  parameter int DIV_W   = 12,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_rst,
  input  logic [DIV_W-1:0]   etu_div,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               tie,
  input  logic               eie,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               err_clr,
  input  logic               line_in,
  output logic               drive_low,
  output logic               tdre,
  output logic               tend,
  output logic               err_flag,
  output logic               txi,
  output logic               eri
);
  localparam logic [3:0] SLOT_PAR  = 4'd9;
  localparam logic [3:0] SLOT_ERR  = 4'd10;
  localparam logic [3:0] SLOT_LAST = 4'd12;

  logic               busy;
  logic [DIV_W-1:0]   cnt;
  logic [3:0]         slot;
  logic [7:0]         tdr;
  logic [8:0]         tsr;
  logic [RETRY_W-1:0] retries;
  logic               nack;

  wire etu_end  = (cnt == etu_div - 1'b1);
  wire mid_err  = busy && (slot == SLOT_ERR) && (cnt == (etu_div >> 1));
  wire err_seen = mid_err && !line_in;
  wire at_limit = (retry_max != '0) && (retries == retry_max);

  assign drive_low = busy && (slot <= SLOT_PAR) && ((slot == 4'd0) || !tsr[0]);
  assign txi = tie & tdre & tend;
  assign eri = eie & err_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; slot <= '0; tdr <= '0; tsr <= '0;
      retries <= '0; nack <= 1'b0; tdre <= 1'b1; tend <= 1'b1;
    end else if (sw_rst) begin
      busy <= 1'b0; cnt <= '0; slot <= '0; retries <= '0; nack <= 1'b0;
      tdre <= 1'b1; tend <= 1'b1;
    end else if (!busy) begin
      if (wr_en && tdre) begin
        tdr  <= wr_data;
        tsr  <= {^wr_data, wr_data};
        tdre <= 1'b0;
        tend <= 1'b0;
        busy <= 1'b1;
        cnt  <= '0;
        slot <= '0;
        nack <= 1'b0;
      end
    end else begin
      if (mid_err) nack <= !line_in;
      if (etu_end) begin
        cnt <= '0;
        if (slot >= 4'd1 && slot <= 4'd8) tsr <= tsr >> 1;
        if (slot == SLOT_LAST) begin
          if (nack) begin
            if (at_limit) busy <= 1'b0;
            else begin
              retries <= retries + 1'b1;
              tsr     <= {^tdr, tdr};
              slot    <= '0;
              nack    <= 1'b0;
            end
          end else begin
            busy    <= 1'b0;
            tdre    <= 1'b1;
            tend    <= 1'b1;
            retries <= '0;
          end
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_flag <= 1'b0;
    else if (err_seen) err_flag <= 1'b1;
    else if (err_clr)  err_flag <= 1'b0;
  end

  AST_TEND_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tend); // R6
  AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!tdre && !tend)); // R3
  AST_LATE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tdre && wr_en && !sw_rst) |=> $stable(tdr)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R8
  AST_TEND_WITH_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> tdre); // R7
endmodule

// File: tb/test_sc_tx_retry.sv
module test_sc_tx_retry;
  logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0;
  logic [11:0] etu_div = 12'd8;
  logic [2:0] retry_max = 3'd0;
  logic tie = 1'b0, eie = 1'b0, wr_en = 1'b0, err_clr = 1'b0, card_low = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic drive_low, tdre, tend, err_flag, txi, eri, line_in;
  int nchk = 0, nfail = 0, frames = 0, etu = 8;
  logic [7:0] q_data[$];
  logic q_nack[$];
  logic [7:0] mon_byte;
  logic mon_par, mon_nack, mon_rel;

  always #10 clk = ~clk;
  assign line_in = ~(drive_low | card_low);

  sc_tx_retry #(.DIV_W(12), .RETRY_W(3)) i_sc_tx_retry (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .etu_div(etu_div), .retry_max(retry_max),
    .tie(tie), .eie(eie), .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr),
    .line_in(line_in), .drive_low(drive_low), .tdre(tdre), .tend(tend),
    .err_flag(err_flag), .txi(txi), .eri(eri));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [7:0] d, input logic nk);
    q_data.push_back(d);
    q_nack.push_back(nk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // monitor and card model: decodes frames, rejects on request
  initial forever begin
    @(negedge clk);
    if (rst_n && drive_low) begin
      mon_nack = (q_nack.size() > 0) ? q_nack[0] : 1'b0;
      repeat (etu / 2) @(negedge clk);
      chk(drive_low == 1'b1, "R2 start bit", drive_low, 1);
      for (int k = 0; k < 8; k++) begin
        repeat (etu) @(negedge clk);
        mon_byte[k] = ~drive_low;
      end
      repeat (etu) @(negedge clk);
      mon_par = ~drive_low;
      repeat (etu - etu / 2) @(negedge clk);
      card_low = mon_nack;
      repeat (etu / 2) @(negedge clk);
      mon_rel = ~drive_low;
      repeat (etu - etu / 2) @(negedge clk);
      card_low = 1'b0;
      chk(mon_rel, "R2 line released in error slot", drive_low, 0);
      chk(mon_par == ^mon_byte, "R2 even parity", mon_par, ^mon_byte);
      frames++;
      if (q_data.size() == 0) chk(1'b0, "R4/R9 unexpected frame", mon_byte, 0);
      else begin
        chk(mon_byte == q_data[0], "R2/R6 frame data", mon_byte, q_data[0]);
        void'(q_data.pop_front());
        void'(q_nack.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int n, f0;
    bit txi_seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tdre && tend, "R1 flags after reset", {tdre, tend}, 3);
    chk(!err_flag && !drive_low, "R1 error/line after reset", {err_flag, drive_low}, 0);
    tie = 1'b1; #1;
    chk(txi == 1'b1, "R7 txi from idle flags", txi, 1);

    // clean frame
    expect_frame(8'hA5, 1'b0);
    write_byte(8'hA5);
    chk(!tdre && !tend && drive_low, "R3 write clears flags, start driven", {tdre, tend, drive_low}, 1);
    n = 0;
    while (!tend && n < 5000) begin @(negedge clk); n++; end
    chk(n == 13 * etu, "R7 completion cycle", n, 13 * etu);
    chk(tdre && txi && !err_flag, "R7 flags together, no error", {tdre, txi, err_flag}, 6);

    // write while busy ignored
    expect_frame(8'h81, 1'b0);
    write_byte(8'h81);
    repeat (20) @(negedge clk);
    write_byte(8'h7E);
    chk(!tdre, "R4 tdre stays 0 after late write", tdre, 0);
    while (!tend) @(negedge clk);
    repeat (3 * etu) @(negedge clk);
    chk(q_data.size() == 0 && !drive_low, "R4 no extra frame", q_data.size(), 0);

    // one rejection then acceptance
    eie = 1'b1;
    expect_frame(8'h3C, 1'b1);
    expect_frame(8'h3C, 1'b0);
    write_byte(8'h3C);
    n = 0;
    while (!err_flag && n < 5000) begin @(negedge clk); n++; end
    chk(n == 10 * etu + etu / 2 + 1, "R5 error sample cycle", n, 10 * etu + etu / 2 + 1);
    chk(eri && !tend, "R5 eri raised, tend low", {eri, tend}, 2);
    txi_seen = 1'b0;
    while (!tend && n < 5000) begin @(negedge clk); n++; if (!tend) txi_seen |= txi | tdre; end
    chk(n == 26 * etu, "R6 resend completion", n, 26 * etu);
    chk(!txi_seen, "R6 no txi/tdre during resend", txi_seen, 0);
    chk(err_flag == 1'b1, "R8 error sticky after success", err_flag, 1);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(!err_flag && !eri, "R8 err_clr clears", err_flag, 0);

    // unlimited resends
    retry_max = 3'd0;
    f0 = frames;
    for (int i = 0; i < 3; i++) expect_frame(8'hC3, 1'b1);
    expect_frame(8'hC3, 1'b0);
    write_byte(8'hC3);
    n = 0;
    while (!tend && n < 5000) begin @(negedge clk); n++; end
    chk(n == 52 * etu, "R9 unlimited resends complete", n, 52 * etu);
    repeat (2) @(negedge clk);
    chk(frames - f0 == 4, "R9 frame count unlimited", frames - f0, 4);

    // retry cap with odd divider
    etu = 5; etu_div = 12'd5; retry_max = 3'd2;
    f0 = frames;
    for (int i = 0; i < 3; i++) expect_frame(8'h96, 1'b1);
    write_byte(8'h96);
    repeat (3 * 13 * etu + 20 * etu) @(negedge clk);
    chk(!tend && !tdre, "R9 stalled flags", {tend, tdre}, 0);
    chk(frames - f0 == 3, "R9 frames at cap", frames - f0, 3);
    write_byte(8'h11);
    repeat (20 * etu) @(negedge clk);
    chk(frames - f0 == 3 && !drive_low, "R9 write ignored while stalled", frames - f0, 3);
    @(negedge clk); sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    chk(tdre && tend && err_flag, "R9 soft reset restores flags, keeps error", {tdre, tend, err_flag}, 7);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;

    // clean frame, odd divider, odd parity data
    expect_frame(8'h01, 1'b0);
    write_byte(8'h01);
    n = 0;
    while (!tend && n < 5000) begin @(negedge clk); n++; end
    chk(n == 13 * etu, "R7 completion with odd divider", n, 13 * etu);
    chk(!err_flag, "R7 error flag unchanged", err_flag, 0);
    repeat (4) @(negedge clk);
    chk(q_data.size() == 0, "R2 all expected frames seen", q_data.size(), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule